// File: doc/BRIEF.md
# Oversampled Output Ring Scheduler

The block plays out pre-loaded bit patterns on four digital outputs, eight sub-slots per bus cycle. Every channel owns a circular store of 256 one-bit entries. A read position walks through the store at one entry per sub-slot, so it grows by eight per bus cycle. Each entry it reaches is driven onto the channel output for one sub-slot. The host watches the exported read position. It refills the store ahead of it through a write port. Each write carries a start address and an 8-bit pattern per channel.

The block guards the refill. A write whose start address lies more than 128 entries ahead of the read position is refused, and a sticky copy error is raised. An entry that has been played is marked used. If the read position reaches a used entry while playback is active, the host did not refill in time: the outputs are forced low for that sub-slot and a sticky control error is raised. Playback is armed once by a copy-active input, and any later change of that input is also a control error. Each error flag has its own quit input that clears it.

Top module: `osOutRing`

## Requirements
- R1: After reset, readPos is 0, dout is 0, controlErr and copyErr are 0, and every entry of the store is marked used.
- R2: A sub-slot lasts SLOT_CLKS = CYCLE_CLKS/8 clocks. While ctrlEnable is high, the position advances by one at the end of each sub-slot and wraps from 255 to 0. A rising ctrlEnable restarts the position at 0. readPos follows the position while enabled and holds its last value while disabled.
- R3: An accepted write stores wrPattern bit 8*c+i in channel c at address (wrAddr+i) mod 256, for i = 0..7. Bit i = 0 lands at the lowest address and is therefore played first. The write clears the used marks of those eight entries.
- R4: A write is accepted only if (wrAddr - position) mod 256 <= 128. Otherwise nothing is stored and copyErr is set at the next clock edge.
- R5: While ctrlEnable and ctrlCopyActive are high, dout[c] takes the entry of channel c at the current position on the first clock of each sub-slot. It holds that value for the rest of the sub-slot, and the entry becomes marked used.
- R6: When the position reaches an entry that is already marked used while playback is active, all of dout are 0 for that sub-slot and controlErr is set.
- R7: The first rise of ctrlCopyActive raises no error. Any later change of ctrlCopyActive, falling or rising, sets controlErr.
- R8: dout is 0 in every clock after one in which ctrlEnable or ctrlCopyActive is low.
- R9: Both error flags are sticky. A high quit input clears its flag at the next edge, but a new error in that same clock keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlEnable | input | 1 | Runs the sub-slot timer and the read position |
| ctrlCopyActive | input | 1 | Arms playback of stored entries onto dout |
| wrValid | input | 1 | Write request, one clock per write |
| wrAddr | input | 8 | Start address of the eight-entry group |
| wrPattern | input | NUM_CH*8 | One 8-bit pattern per channel, channel c in bits 8c+7..8c |
| quitControlErr | input | 1 | Clears controlErr |
| quitCopyErr | input | 1 | Clears copyErr |
| readPos | output | 8 | Exported read position |
| dout | output | NUM_CH | Oversampled channel outputs |
| controlErr | output | 1 | Sticky underrun or copy-active change error |
| copyErr | output | 1 | Sticky out-of-window write error |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that the host never writes an eight-entry group covering the entry consumed in the same clock, because the ordering of that collision is not part of any requirement. The stimulus keeps every refill between one and 64 entries ahead of the exported position, so the groups it writes stay well clear of the read point. Out-of-window writes, overlapping quit and error events, and copy-active changes are applied only as directed cases, at clocks the bench picks from readPos.

// File: rtl/osr_pkg.sv
package osr_pkg;
  // Ring address width: 256 entries per channel.
  localparam int OSR_AW = 8;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic              consume;   // first clock of a sub-slot while enabled
    logic              drive;     // enabled and copy-active
    logic              wrAccept;  // write passed the window check
    logic [OSR_AW-1:0] pos;       // current read position
  } osrStrobe_t;
endpackage

// File: rtl/osrControl.sv
module osrControl
  import osr_pkg::*;
#(
  parameter int GROUP      = 8,
  parameter int CYCLE_CLKS = 64,
  parameter int WINDOW     = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlEnable,
  input  logic              ctrlCopyActive,
  input  logic              wrValid,
  input  logic [OSR_AW-1:0] wrAddr,
  input  logic              quitControlErr,
  input  logic              quitCopyErr,
  input  logic              underrun,
  output osrStrobe_t        strb,
  output logic [OSR_AW-1:0] readPos,
  output logic              controlErr,
  output logic              copyErr
);
  localparam int SLOT_CLKS = (CYCLE_CLKS / GROUP > 0) ? CYCLE_CLKS / GROUP : 1;
  localparam int SW        = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

  logic [SW-1:0]     slotCnt;
  logic [OSR_AW-1:0] posQ;
  logic [OSR_AW-1:0] readPosQ;
  logic [OSR_AW-1:0] aheadDist;
  logic              slotLast;
  logic              wrReject;
  logic              caPrev;
  logic              caEver;
  logic              caChange;

  assign slotLast  = (slotCnt == SW'(SLOT_CLKS - 1));
  assign aheadDist = wrAddr - posQ;
  assign wrReject  = wrValid && ({1'b0, aheadDist} > (OSR_AW + 1)'(WINDOW));
  assign caChange  = caEver && (ctrlCopyActive != caPrev);

  always_comb begin
    strb.consume  = ctrlEnable && (slotCnt == '0);
    strb.drive    = ctrlEnable && ctrlCopyActive;
    strb.wrAccept = wrValid && !wrReject;
    strb.pos      = posQ;
  end

  // Sub-slot timer and read position.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt  <= '0;
      posQ     <= '0;
      readPosQ <= '0;
    end else if (!ctrlEnable) begin
      slotCnt <= '0;
      posQ    <= '0;
    end else if (slotLast) begin
      slotCnt  <= '0;
      posQ     <= posQ + OSR_AW'(1);
      readPosQ <= posQ + OSR_AW'(1);
    end else begin
      slotCnt  <= slotCnt + SW'(1);
      readPosQ <= posQ;
    end
  end

  // Copy-active history and sticky error flags.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      caPrev     <= 1'b0;
      caEver     <= 1'b0;
      copyErr    <= 1'b0;
      controlErr <= 1'b0;
    end else begin
      caPrev     <= ctrlCopyActive;
      if (ctrlCopyActive) caEver <= 1'b1;
      copyErr    <= (copyErr && !quitCopyErr) || wrReject;
      controlErr <= (controlErr && !quitControlErr) || underrun || caChange;
    end
  end

  assign readPos = readPosQ;

  // R2: the position moves by at most one per clock while enabled
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrlEnable) |-> (posQ == $past(posQ)) || (posQ == $past(posQ) + OSR_AW'(1)));

  // R4: a write outside the window leaves copyErr set
  a_r4_reject_flags: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !strb.wrAccept |=> copyErr);

  // R6: an underrun raises controlErr
  a_r6_flag: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> controlErr);

  // R7: a copy-active change after arming raises controlErr
  a_r7_change_flags: assert property (@(posedge clk) disable iff (!rstN)
    caEver && (ctrlCopyActive != caPrev) |=> controlErr);

  // R9: flags hold until their quit input
  a_r9_copy_sticky: assert property (@(posedge clk) disable iff (!rstN)
    copyErr && !quitCopyErr |=> copyErr);
  a_r9_ctl_sticky: assert property (@(posedge clk) disable iff (!rstN)
    controlErr && !quitControlErr |=> controlErr);
endmodule

// File: rtl/osrDatapath.sv
module osrDatapath
  import osr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int GROUP  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  osrStrobe_t              strb,
  input  logic [OSR_AW-1:0]       wrAddr,
  input  logic [NUM_CH*GROUP-1:0] wrPattern,
  output logic                    underrun,
  output logic [NUM_CH-1:0]       dout
);
  localparam int DEPTH = 1 << OSR_AW;
  localparam int GW    = (GROUP > 1) ? $clog2(GROUP) : 1;

  logic [DEPTH-1:0]  usedQ;
  logic [DEPTH-1:0]  wrHit;
  logic [OSR_AW-1:0] entryOff [DEPTH];
  logic [GW-1:0]     bitSel   [DEPTH];
  logic [NUM_CH-1:0] slotBits;

  // Which entries a write fills, and which pattern bit each takes.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      entryOff[i] = OSR_AW'(i) - wrAddr;
      bitSel[i]   = entryOff[i][GW-1:0];
      wrHit[i]    = strb.wrAccept && (entryOff[i] < OSR_AW'(GROUP));
    end
  end

  // One ring per channel.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DEPTH-1:0] ringQ;
    logic [GROUP-1:0] pat;
    assign pat = wrPattern[c*GROUP +: GROUP];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ringQ <= '0;
      else begin
        for (int i = 0; i < DEPTH; i++)
          if (wrHit[i]) ringQ[i] <= pat[bitSel[i]];
      end
    end

    assign slotBits[c] = ringQ[strb.pos];
  end

  assign underrun = strb.consume && strb.drive && usedQ[strb.pos];

  // Used marks: a write clears, a consume sets; the write wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) usedQ <= '1;
    else begin
      if (strb.consume && strb.drive) usedQ[strb.pos] <= 1'b1;
      for (int i = 0; i < DEPTH; i++)
        if (wrHit[i]) usedQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dout <= '0;
    else if (!strb.drive)  dout <= '0;
    else if (strb.consume) dout <= underrun ? '0 : slotBits;
  end

  // R5: a played entry is marked used unless rewritten in the same clock
  a_r5_mark_used: assert property (@(posedge clk) disable iff (!rstN)
    strb.consume && strb.drive && !wrHit[strb.pos] |=> usedQ[$past(strb.pos)]);

  // R6: an underrun forces every output low
  a_r6_low_on_underrun: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> dout == '0);

  // R8: outputs are low after a clock without playback
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !strb.drive |=> dout == '0);

  // R3: an accepted write leaves its start entry unused
  a_r3_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrAccept |=> !usedQ[$past(wrAddr)]);
endmodule

// File: rtl/osOutRing.sv
module osOutRing
  import osr_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int GROUP      = 8,
  parameter int CYCLE_CLKS = 64,
  parameter int WINDOW     = 128
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ctrlEnable,
  input  logic                    ctrlCopyActive,
  input  logic                    wrValid,
  input  logic [OSR_AW-1:0]       wrAddr,
  input  logic [NUM_CH*GROUP-1:0] wrPattern,
  input  logic                    quitControlErr,
  input  logic                    quitCopyErr,
  output logic [OSR_AW-1:0]       readPos,
  output logic [NUM_CH-1:0]       dout,
  output logic                    controlErr,
  output logic                    copyErr
);
  osrStrobe_t strb;
  logic       underrun;

  osrControl #(
    .GROUP(GROUP), .CYCLE_CLKS(CYCLE_CLKS), .WINDOW(WINDOW)
  ) u_control (
    .clk(clk), .rstN(rstN),
    .ctrlEnable(ctrlEnable), .ctrlCopyActive(ctrlCopyActive),
    .wrValid(wrValid), .wrAddr(wrAddr),
    .quitControlErr(quitControlErr), .quitCopyErr(quitCopyErr),
    .underrun(underrun), .strb(strb), .readPos(readPos),
    .controlErr(controlErr), .copyErr(copyErr)
  );

  osrDatapath #(
    .NUM_CH(NUM_CH), .GROUP(GROUP)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .wrPattern(wrPattern),
    .underrun(underrun), .dout(dout)
  );
endmodule

// File: tb/osOutRing_bench.sv
module osOutRing_bench;
  localparam int NUM_CH     = 4;
  localparam int GROUP      = 8;
  localparam int CYCLE_CLKS = 64;
  localparam int SLOT       = CYCLE_CLKS / GROUP;
  localparam int DEPTH      = 256;
  localparam logic [7:0]  SPECIAL = 8'd138;
  localparam logic [31:0] P1 = 32'h5AC3963C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlEnable = 1'b0, ctrlCopyActive = 1'b0, wrValid = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [NUM_CH*GROUP-1:0] wrPattern = '0;
  logic quitControlErr = 1'b0, quitCopyErr = 1'b0;
  logic [7:0] readPos;
  logic [NUM_CH-1:0] dout;
  logic controlErr, copyErr;

  always #2 clk = ~clk;  // 250 MHz

  osOutRing u_osOutRing (
    .clk(clk), .rstN(rstN), .ctrlEnable(ctrlEnable), .ctrlCopyActive(ctrlCopyActive),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrPattern(wrPattern),
    .quitControlErr(quitControlErr), .quitCopyErr(quitCopyErr),
    .readPos(readPos), .dout(dout), .controlErr(controlErr), .copyErr(copyErr)
  );

  int checks = 0;
  int errors = 0;
  bit monOn = 1'b0;
  logic [7:0] nextAddr = 8'd18;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NUM_CH-1:0] bitsAt(logic [31:0] pat, int idx);
    logic [NUM_CH-1:0] r;
    for (int c = 0; c < NUM_CH; c++) r[c] = pat[c*GROUP + idx];
    return r;
  endfunction

  // Reference model built from the requirements.
  logic [7:0]        mPos = '0, mReadPos = '0;
  int                mSlot = 0;
  logic [NUM_CH-1:0] mDout = '0;
  logic              mUsed [DEPTH];
  logic [NUM_CH-1:0] mBuf  [DEPTH];
  logic mCaPrev = 0, mCaEver = 0, mCtl = 0, mCpy = 0;

  initial for (int i = 0; i < DEPTH; i++) begin mUsed[i] = 1'b1; mBuf[i] = '0; end

  always @(posedge clk) begin : model
    logic under, rej, tog;
    logic [7:0] d;
    logic [7:0] a;
    if (!rstN) begin
      mPos = '0; mReadPos = '0; mSlot = 0; mDout = '0;
      mCaPrev = 0; mCaEver = 0; mCtl = 0; mCpy = 0;
      for (int i = 0; i < DEPTH; i++) begin mUsed[i] = 1'b1; mBuf[i] = '0; end
    end else begin
      under = 1'b0;
      d   = wrAddr - mPos;
      rej = wrValid && (d > 8'd128);
      if (!ctrlEnable) begin
        mSlot = 0; mPos = '0; mDout = '0;
      end else begin
        if (!ctrlCopyActive) mDout = '0;
        else if (mSlot == 0) begin
          if (mUsed[mPos]) begin under = 1'b1; mDout = '0; end
          else mDout = mBuf[mPos];
          mUsed[mPos] = 1'b1;
        end
        if (mSlot == SLOT - 1) begin mSlot = 0; mPos = mPos + 8'd1; end
        else mSlot++;
        mReadPos = mPos;
      end
      if (wrValid && !rej)
        for (int i = 0; i < GROUP; i++) begin
          a = wrAddr + 8'(i);
          mBuf[a]  = bitsAt(wrPattern, i);
          mUsed[a] = 1'b0;
        end
      tog = mCaEver && (ctrlCopyActive != mCaPrev);
      mCaPrev = ctrlCopyActive;
      if (ctrlCopyActive) mCaEver = 1'b1;
      mCpy = (mCpy && !quitCopyErr) || rej;
      mCtl = (mCtl && !quitControlErr) || under || tog;
    end
  end

  always @(negedge clk) if (rstN && monOn) begin
    chk("R2 readPos vs model", 32'(readPos), 32'(mReadPos));
    chk("R5 dout vs model", 32'(dout), 32'(mDout));
    chk("R4 copyErr vs model", 32'(copyErr), 32'(mCpy));
    chk("R6 controlErr vs model", 32'(controlErr), 32'(mCtl));
  end

  // One host clock: refill ahead of readPos when feeding.
  task automatic hostClock(bit feed);
    logic [7:0] d;
    d = nextAddr - readPos;
    wrValid = 1'b0;
    if (feed && d <= 8'd64) begin
      if (nextAddr == SPECIAL) nextAddr = nextAddr + 8'd8;
      else begin
        wrValid   = 1'b1;
        wrAddr    = nextAddr;
        wrPattern = 32'($urandom());
        nextAddr  = nextAddr + 8'd8;
      end
    end
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic runUntilPos(logic [7:0] target, bit feed);
    for (int i = 0; i < 6000; i++) begin
      if (readPos == target) break;
      hostClock(feed);
    end
    chk("R2 position reached", 32'(readPos), 32'(target));
  endtask

  task automatic doWrite(logic [7:0] addr, logic [31:0] pat);
    wrValid = 1'b1; wrAddr = addr; wrPattern = pat;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic waitSlotStart();
    logic [7:0] p;
    p = readPos;
    for (int i = 0; i < 4 * SLOT; i++) begin
      @(negedge clk);
      if (readPos != p) break;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] held;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 readPos after reset", 32'(readPos), 32'd0);
    chk("R1 dout after reset", 32'(dout), 32'd0);
    chk("R1 controlErr after reset", 32'(controlErr), 32'd0);
    chk("R1 copyErr after reset", 32'(copyErr), 32'd0);
    monOn = 1'b1;

    // R2: ten sub-slots of eight clocks
    ctrlEnable = 1'b1;
    repeat (10 * SLOT) @(negedge clk);
    chk("R2 readPos after ten slots", 32'(readPos), 32'd10);

    // R4 window edge: distance 128 accepted, 129 refused
    doWrite(8'd138, P1);
    chk("R4 distance 128 accepted", 32'(copyErr), 32'd0);
    doWrite(8'd139, ~P1);
    chk("R4 distance 129 refused", 32'(copyErr), 32'd1);
    quitCopyErr = 1'b1; @(negedge clk); quitCopyErr = 1'b0;
    chk("R9 quit clears copyErr", 32'(copyErr), 32'd0);
    // R4 behind the position (wraps to 255) is refused; R9 error beats quit
    quitCopyErr = 1'b1;
    doWrite(readPos - 8'd1, 32'hFFFFFFFF);
    quitCopyErr = 1'b0;
    chk("R9 new error wins over quit", 32'(copyErr), 32'd1);
    quitCopyErr = 1'b1; @(negedge clk); quitCopyErr = 1'b0;
    chk("R9 copyErr cleared again", 32'(copyErr), 32'd0);

    // Refill, then arm playback on written data
    runUntilPos(8'd19, 1'b1);
    ctrlCopyActive = 1'b1;
    repeat (3 * SLOT) hostClock(1'b1);
    chk("R7 first arming raises nothing", 32'(controlErr), 32'd0);

    // R3/R4: entry 140 holds bit 2 of the accepted group, not the refused one
    runUntilPos(8'd140, 1'b1);
    hostClock(1'b1);
    chk("R3 R4 entry 140 plays accepted pattern", 32'(dout), 32'(bitsAt(P1, 2)));
    hostClock(1'b1);
    chk("R5 value holds within the slot", 32'(dout), 32'(bitsAt(P1, 2)));

    // R2 wrap from 255 to 0
    runUntilPos(8'd255, 1'b1);
    repeat (SLOT) hostClock(1'b1);
    chk("R2 wrap to zero", 32'(readPos), 32'd0);
    chk("R6 no underrun while refilled", 32'(controlErr), 32'd0);

    // R6: stop refilling until an underrun
    for (int i = 0; i < 4000; i++) begin
      if (controlErr) break;
      hostClock(1'b0);
    end
    chk("R6 underrun flags controlErr", 32'(controlErr), 32'd1);
    chk("R6 outputs low on underrun", 32'(dout), 32'd0);

    // R9: quit on a consuming clock is overridden, then clears
    waitSlotStart();
    quitControlErr = 1'b1; @(negedge clk);
    chk("R9 underrun wins over quit", 32'(controlErr), 32'd1);
    @(negedge clk); quitControlErr = 1'b0;
    chk("R9 quit clears controlErr", 32'(controlErr), 32'd0);

    // R7/R8: dropping copy-active is an error and silences outputs
    ctrlCopyActive = 1'b0; @(negedge clk);
    chk("R7 clearing copy-active flags", 32'(controlErr), 32'd1);
    chk("R8 outputs low without copy-active", 32'(dout), 32'd0);
    quitControlErr = 1'b1; @(negedge clk); quitControlErr = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 steady copy-active raises nothing", 32'(controlErr), 32'd0);
    ctrlCopyActive = 1'b1; @(negedge clk);
    chk("R7 re-arming flags", 32'(controlErr), 32'd1);

    // R2/R8: disable holds readPos and silences outputs; enable restarts
    ctrlEnable = 1'b0; @(negedge clk);
    held = readPos;
    repeat (40) @(negedge clk);
    chk("R2 readPos holds while disabled", 32'(readPos), 32'(held));
    chk("R8 outputs low while disabled", 32'(dout), 32'd0);
    ctrlEnable = 1'b1;
    repeat (SLOT) @(negedge clk);
    chk("R2 restart from zero", 32'(readPos), 32'd1);

    monOn = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule